// File: doc/BRIEF.md
# Flex Bus Alternate Protocol Negotiation Controller

This block runs the downstream-port side of the two-phase exchange that decides whether a link comes up as CXL or stays PCIe. It works next to link training and does not drive it. It watches the current configuration substate and the link rate. It also receives a stream of already-decoded training-set records, each giving the TS kind (TS1 or TS2), whether the set was a modified one, and the Flex Bus capability bits carried in its protocol-specific info fields.

During lane-number negotiation the block narrows its own capability vector to what the partner also offers. This vector goes out in the transmitted modified sets. During Configuration.Complete the block expects the partner to echo that vector exactly. Eight consecutive matching modified TS2 records finish the negotiation in CXL mode. A differing echo requests a return to Detect. A partner that never sends a modified TS1 leaves the link in PCIe mode.

After success, CXL features are enabled only once the link sits in L0 at 8 GT/s or faster. A later rate drop that lasts for a programmable number of cycles ends CXL operation with a Detect request.

Top module: `flexneg_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `neg_done`, `detect_req`, `mode_cxl` and `cxl_en` are 0 and `flex_caps` is 0. While idle, `flex_caps` follows `local_caps` one cycle later.
- R2: `sub_state` codes are 0 = other, 1 = lane-number wait, 2 = lane-number accept, 3 = configuration complete, 4 = L0. In substates 1 and 2, each record with `rx_valid`=1, `rx_ts2`=0 and `rx_mod`=1 sets `flex_caps` to `local_caps & rx_caps` on the next cycle. A TS1 with `rx_mod`=0 leaves `flex_caps` unchanged.
- R3: If no modified TS1 arrived during substates 1 and 2, then on reaching substate 3 the block pulses `neg_done` for one cycle with `mode_cxl`=0.
- R4: In substate 3 after a modified TS1 exchange, a modified TS2 whose `rx_caps` equals `flex_caps` is a match. On the eighth consecutive match, `neg_done` pulses for one cycle and `mode_cxl` becomes 1.
- R5: A TS2 with `rx_mod`=0 in substate 3 restarts the consecutive-match count from zero.
- R6: A modified TS2 in substate 3 whose `rx_caps` differs from `flex_caps` pulses `detect_req` for one cycle, and no `neg_done` follows.
- R7: After CXL success, `cxl_en` rises only in a cycle after `sub_state`=4 with `link_rate` >= 2 (rate codes 0 = 2.5, 1 = 5, 2 = 8, 3 = 16 GT/s and up). It stays 0 in L0 at codes 0 and 1.
- R8: While `cxl_en`=1, `link_rate` below code 2 for `recov_limit` consecutive cycles pulses `detect_req` and clears `cxl_en` and `mode_cxl`. A shorter dip keeps `cxl_en` high and restarts the count.
- R9: `flex_caps` does not change during phase 2. TS1 records received in substate 3 are ignored.
- R10: `sub_state`=0 returns the block to idle from any phase. This clears `mode_cxl` and `cxl_en` without a `detect_req` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_state | input | 3 | Training substate code (see R2) |
| link_rate | input | 3 | Current rate code (see R7) |
| rx_valid | input | 1 | A decoded received training-set record is present |
| rx_ts2 | input | 1 | Record is a TS2 (0 = TS1) |
| rx_mod | input | 1 | Record is a modified training set |
| rx_caps | input | 8 | Flex Bus capability bits from the record's info fields |
| local_caps | input | 8 | Capabilities this port supports |
| recov_limit | input | 16 | Low-rate cycles tolerated in CXL mode |
| flex_caps | output | 8 | Capability vector to transmit and the agreed result |
| neg_done | output | 1 | One-cycle pulse when negotiation finishes |
| mode_cxl | output | 1 | 1 = CXL result, 0 = PCIe |
| cxl_en | output | 1 | CXL features may be used |
| detect_req | output | 1 | One-cycle request to return to Detect |

## Verification
The hardest situations to reach are the count boundaries. One is a TS2 match streak that is broken by a plain TS2 just before it completes and then rebuilt from zero. The other is a rate dip that ends one cycle short of the recovery limit, followed by one that reaches it. Both can only be reached after walking the block through a full phase-1 exchange and into the matching phase or into L0. The stimulus therefore drives complete negotiations through the substate sequence and places the interrupting record or rate change on an exact cycle. A behavioural model in the bench follows every cycle alongside the design.

// File: rtl/flexneg_pkg.sv
// Shared encodings for the Flex Bus negotiation controller.
// Assumes the substate codes listed in the brief are produced by the link trainer.
package flexneg_pkg;
    typedef enum logic [2:0] {
        SUB_OTHER    = 3'd0,
        SUB_LN_WAIT  = 3'd1,
        SUB_LN_ACC   = 3'd2,
        SUB_CFG_DONE = 3'd3,
        SUB_LINK_UP  = 3'd4
    } sub_e;

    typedef enum logic [2:0] {
        NG_IDLE = 3'd0,
        NG_PH1  = 3'd1,
        NG_PH2  = 3'd2,
        NG_CXL  = 3'd3,
        NG_PCIE = 3'd4,
        NG_FAIL = 3'd5
    } neg_e;
endpackage

// File: rtl/flexneg_caps.sv
// Capability agreement register.
// While idle it tracks the local capabilities. During phase 1, each received
// modified TS1 narrows it to local & received. It also records whether any
// modified TS1 arrived at all.
// Assumes follow_local and take_rx are never asserted together.
module flexneg_caps #(
    parameter int CAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             follow_local,
    input  logic             take_rx,
    input  logic [CAP_W-1:0] local_caps,
    input  logic [CAP_W-1:0] rx_caps,
    output logic [CAP_W-1:0] caps,
    output logic             seen_mod
);
    // Hold, reload or narrow the agreed vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            caps     <= '0;
            seen_mod <= 1'b0;
        end else if (follow_local) begin
            caps     <= local_caps;
            seen_mod <= 1'b0;
        end else if (take_rx) begin
            caps     <= local_caps & rx_caps;
            seen_mod <= 1'b1;
        end
    end

    // R2
    caps_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_rx |=> ((caps & ~$past(local_caps)) == '0) && seen_mod);
endmodule

// File: rtl/flexneg_match.sv
// Counter of consecutive matching modified TS2 records.
// last is high in the cycle that brings in the MATCH_N-th match.
// Assumes hit and flush are never asserted together.
module flexneg_match #(
    parameter int MATCH_N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic hit,
    input  logic flush,
    output logic last
);
    localparam int CNT_W = $clog2(MATCH_N + 1);

    logic [CNT_W-1:0] cnt;

    assign last = hit && (cnt == CNT_W'(MATCH_N - 1));

    // Count matches, restarting on a plain TS2 or outside phase 2.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || flush) begin
            cnt <= '0;
        end else if (hit) begin
            cnt <= last ? '0 : cnt + CNT_W'(1);
        end
    end

    // R4
    match_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(MATCH_N));
    // R5
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));
endmodule

// File: rtl/flexneg_rate_mon.sv
// Low-rate recovery timer for CXL operation.
// expire is high in the cycle of the limit-th consecutive low-rate cycle.
// Any recovery, or disarming, restarts the count. A limit of 0 acts as 1.
module flexneg_rate_mon #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             rate_low,
    input  logic [TMR_W-1:0] limit,
    output logic             expire
);
    logic [TMR_W-1:0] cnt;
    logic [TMR_W:0]   nxt;

    assign nxt    = {1'b0, cnt} + {{TMR_W{1'b0}}, 1'b1};
    assign expire = arm && rate_low && (nxt >= {1'b0, limit});

    // Advance while armed and slow, otherwise restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || !rate_low || expire) begin
            cnt <= '0;
        end else begin
            cnt <= nxt[TMR_W-1:0];
        end
    end

    // R8
    tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0 && $stable(limit)) |-> (cnt < limit));
endmodule

// File: rtl/flexneg_ctrl.sv
// Downstream-port Flex Bus alternate protocol negotiation controller.
// Phase 1 (lane-number substates) agrees capabilities from modified TS1s.
// Phase 2 (configuration complete) demands MATCH_N consecutive exact echoes
// in modified TS2s. CXL is enabled in L0 at rate code >= RATE_MIN, and is
// dropped with a Detect request after a long enough rate dip.
// Assumes at most one received record per cycle.
module flexneg_ctrl
    import flexneg_pkg::*;
#(
    parameter int CAP_W    = 8,
    parameter int MATCH_N  = 8,
    parameter int TMR_W    = 16,
    parameter int RATE_W   = 3,
    parameter int RATE_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sub_state,
    input  logic [RATE_W-1:0] link_rate,
    input  logic              rx_valid,
    input  logic              rx_ts2,
    input  logic              rx_mod,
    input  logic [CAP_W-1:0]  rx_caps,
    input  logic [CAP_W-1:0]  local_caps,
    input  logic [TMR_W-1:0]  recov_limit,
    output logic [CAP_W-1:0]  flex_caps,
    output logic              neg_done,
    output logic              mode_cxl,
    output logic              cxl_en,
    output logic              detect_req
);
    neg_e state;
    sub_e sub;
    logic in_ln, rate_ok, seen_mod, take_rx, ph2_rx, caps_eq;
    logic hit, flush, bad, last, expire;

    assign sub     = sub_e'(sub_state);
    assign in_ln   = (sub == SUB_LN_WAIT) || (sub == SUB_LN_ACC);
    assign rate_ok = link_rate >= RATE_W'(RATE_MIN);
    assign take_rx = (state == NG_PH1) && in_ln && rx_valid && !rx_ts2 && rx_mod;
    assign ph2_rx  = (state == NG_PH2) && (sub == SUB_CFG_DONE) && rx_valid && rx_ts2;
    assign caps_eq = rx_caps == flex_caps;
    assign hit     = ph2_rx && rx_mod && caps_eq;
    assign flush   = ph2_rx && !rx_mod;
    assign bad     = ph2_rx && rx_mod && !caps_eq;

    flexneg_caps #(.CAP_W(CAP_W)) u_caps (
        .clk(clk), .rst_n(rst_n),
        .follow_local(state == NG_IDLE), .take_rx(take_rx),
        .local_caps(local_caps), .rx_caps(rx_caps),
        .caps(flex_caps), .seen_mod(seen_mod)
    );

    flexneg_match #(.MATCH_N(MATCH_N)) u_match (
        .clk(clk), .rst_n(rst_n),
        .enable(state == NG_PH2), .hit(hit), .flush(flush), .last(last)
    );

    flexneg_rate_mon #(.TMR_W(TMR_W)) u_rate (
        .clk(clk), .rst_n(rst_n),
        .arm((state == NG_CXL) && cxl_en), .rate_low(!rate_ok),
        .limit(recov_limit), .expire(expire)
    );

    // Negotiation sequencing and result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= NG_IDLE;
            neg_done   <= 1'b0;
            detect_req <= 1'b0;
            mode_cxl   <= 1'b0;
            cxl_en     <= 1'b0;
        end else begin
            neg_done   <= 1'b0;
            detect_req <= 1'b0;
            case (state)
                NG_IDLE: begin
                    if (in_ln) begin
                        state <= NG_PH1;
                    end else if (sub == SUB_CFG_DONE) begin
                        state    <= NG_PCIE;
                        neg_done <= 1'b1;
                    end
                end
                NG_PH1: begin
                    if (sub == SUB_CFG_DONE) begin
                        if (seen_mod) begin
                            state <= NG_PH2;
                        end else begin
                            state    <= NG_PCIE;
                            neg_done <= 1'b1;
                        end
                    end else if (sub == SUB_OTHER) begin
                        state <= NG_IDLE;
                    end
                end
                NG_PH2: begin
                    if (sub == SUB_OTHER) begin
                        state <= NG_IDLE;
                    end else if (bad) begin
                        state      <= NG_FAIL;
                        detect_req <= 1'b1;
                    end else if (last) begin
                        state    <= NG_CXL;
                        neg_done <= 1'b1;
                        mode_cxl <= 1'b1;
                    end
                end
                NG_CXL: begin
                    if (sub == SUB_OTHER) begin
                        state    <= NG_IDLE;
                        mode_cxl <= 1'b0;
                        cxl_en   <= 1'b0;
                    end else if (expire) begin
                        state      <= NG_FAIL;
                        detect_req <= 1'b1;
                        mode_cxl   <= 1'b0;
                        cxl_en     <= 1'b0;
                    end else if ((sub == SUB_LINK_UP) && rate_ok) begin
                        cxl_en <= 1'b1;
                    end
                end
                default: begin
                    if (sub == SUB_OTHER) begin
                        state    <= NG_IDLE;
                        mode_cxl <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        neg_done |=> !neg_done);
    // R6
    detect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detect_req |=> !detect_req);
    // R6
    done_detect_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(neg_done && detect_req));
    // R7
    en_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cxl_en |-> mode_cxl);
    // R7
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cxl_en) |-> $past((sub_state == 3'd4) && rate_ok));
    // R9
    ph2_caps_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == NG_PH2) && ($past(state) == NG_PH2)) |-> $stable(flex_caps));
endmodule

// File: tb/flexneg_ctrl_bench.sv
// Self-checking bench: a behavioural reference model steps once per clock
// from the same inputs, and every output is compared at each falling edge.
module flexneg_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sub_state = 3'd0;
    logic [2:0] link_rate = 3'd0;
    logic       rx_valid = 1'b0, rx_ts2 = 1'b0, rx_mod = 1'b0;
    logic [7:0] rx_caps = 8'h00;
    logic [7:0] local_caps = 8'hB7;
    logic [15:0] recov_limit = 16'd5;
    logic [7:0] flex_caps;
    logic       neg_done, mode_cxl, cxl_en, detect_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string req = "R1";

    // Reference model state (phase: 0 idle,1 ph1,2 ph2,3 cxl,4 pcie,5 fail)
    int m_phase = 0;
    int m_streak = 0;
    int m_slow = 0;
    bit m_seen = 0;
    logic [7:0] m_caps = 8'h00;
    bit m_done = 0, m_det = 0, m_mode = 0, m_en = 0;

    always #5 clk = ~clk;

    flexneg_ctrl u_flexneg_ctrl (
        .clk(clk), .rst_n(rst_n), .sub_state(sub_state), .link_rate(link_rate),
        .rx_valid(rx_valid), .rx_ts2(rx_ts2), .rx_mod(rx_mod), .rx_caps(rx_caps),
        .local_caps(local_caps), .recov_limit(recov_limit),
        .flex_caps(flex_caps), .neg_done(neg_done), .mode_cxl(mode_cxl),
        .cxl_en(cxl_en), .detect_req(detect_req)
    );

    task automatic model_step();
        bit lim_hit;
        m_done = 0;
        m_det  = 0;
        if (!rst_n) begin
            m_phase = 0; m_streak = 0; m_slow = 0; m_seen = 0;
            m_caps = 8'h00; m_mode = 0; m_en = 0;
            return;
        end
        case (m_phase)
            0: begin
                m_caps = local_caps; m_seen = 0;
                if (sub_state == 1 || sub_state == 2) m_phase = 1;
                else if (sub_state == 3) begin m_phase = 4; m_done = 1; end
            end
            1: begin
                if (sub_state == 3) begin
                    if (m_seen) begin m_phase = 2; m_streak = 0; end
                    else begin m_phase = 4; m_done = 1; end
                end else if (sub_state == 0) m_phase = 0;
                else if ((sub_state == 1 || sub_state == 2) && rx_valid && !rx_ts2 && rx_mod) begin
                    m_caps = local_caps & rx_caps; m_seen = 1;
                end
            end
            2: begin
                if (sub_state == 0) m_phase = 0;
                else if (sub_state == 3 && rx_valid && rx_ts2) begin
                    if (!rx_mod) m_streak = 0;
                    else if (rx_caps != m_caps) begin m_phase = 5; m_det = 1; end
                    else if (m_streak == 7) begin m_phase = 3; m_done = 1; m_mode = 1; m_slow = 0; end
                    else m_streak++;
                end
            end
            3: begin
                lim_hit = 0;
                if (m_en && link_rate < 2) begin
                    if (m_slow + 1 >= int'(recov_limit)) lim_hit = 1;
                    else m_slow++;
                end else m_slow = 0;
                if (sub_state == 0) begin m_phase = 0; m_mode = 0; m_en = 0; end
                else if (lim_hit) begin m_phase = 5; m_det = 1; m_mode = 0; m_en = 0; m_slow = 0; end
                else if (sub_state == 4 && link_rate >= 2) m_en = 1;
            end
            default: begin
                if (sub_state == 0) begin m_phase = 0; m_mode = 0; end
            end
        endcase
    endtask

    task automatic compare();
        checks++;
        if (flex_caps !== m_caps || neg_done !== m_done || detect_req !== m_det ||
            mode_cxl !== m_mode || cxl_en !== m_en) begin
            errors++;
            $display("FAIL %s: caps/done/det/mode/en actual %h/%b/%b/%b/%b expected %h/%b/%b/%b/%b",
                     req, flex_caps, neg_done, detect_req, mode_cxl, cxl_en,
                     m_caps, m_done, m_det, m_mode, m_en);
        end
    endtask

    task automatic chk(input string r, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual %b expected %b", r, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic send(input logic ts2, input logic md, input logic [7:0] c);
        rx_valid = 1'b1; rx_ts2 = ts2; rx_mod = md; rx_caps = c;
        tick();
        rx_valid = 1'b0; rx_mod = 1'b0;
    endtask

    task automatic negotiate_cxl(input logic [7:0] partner);
        sub_state = 3'd1; tick();
        send(1'b0, 1'b1, partner);
        sub_state = 3'd2; tick();
        sub_state = 3'd3; tick();
        for (int i = 0; i < 8; i++) send(1'b1, 1'b1, local_caps & partner);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        req = "R1";
        ticks(3);
        chk("R1", "neg_done in reset", neg_done, 1'b0);
        chk("R1", "cxl_en in reset", cxl_en, 1'b0);
        rst_n = 1'b1;
        tick();
        ticks(2);
        chk("R1", "idle caps follow local", flex_caps == 8'hB7, 1'b1);

        // R2: narrowing by modified TS1; plain TS1 ignored
        req = "R2";
        sub_state = 3'd1; tick();
        send(1'b0, 1'b1, 8'h3F);
        chk("R2", "caps = local & rx", flex_caps == 8'h37, 1'b1);
        send(1'b0, 1'b0, 8'h00);
        chk("R2", "plain TS1 ignored", flex_caps == 8'h37, 1'b1);
        sub_state = 3'd2; tick();

        // R9: phase 2 ignores TS1
        req = "R9";
        sub_state = 3'd3; tick();
        send(1'b0, 1'b1, 8'h01);
        chk("R9", "caps stable in phase 2", flex_caps == 8'h37, 1'b1);

        // R5 then R4: streak broken at 7, rebuilt to 8
        req = "R5";
        for (int i = 0; i < 7; i++) send(1'b1, 1'b1, 8'h37);
        send(1'b1, 1'b0, 8'h37);
        send(1'b1, 1'b1, 8'h37);
        chk("R5", "no done after reset streak", neg_done, 1'b0);
        req = "R4";
        for (int i = 0; i < 6; i++) send(1'b1, 1'b1, 8'h37);
        chk("R4", "no done at seventh", neg_done, 1'b0);
        send(1'b1, 1'b1, 8'h37);
        chk("R4", "done at eighth", neg_done, 1'b1);
        chk("R4", "mode cxl", mode_cxl, 1'b1);
        tick();
        chk("R4", "done is a pulse", neg_done, 1'b0);

        // R7: no enable at 2.5 GT/s in L0, enable at 8 GT/s
        req = "R7";
        sub_state = 3'd4; link_rate = 3'd0; ticks(3);
        chk("R7", "no enable at low rate", cxl_en, 1'b0);
        link_rate = 3'd1; ticks(2);
        chk("R7", "no enable at 5 GT/s", cxl_en, 1'b0);
        link_rate = 3'd2; tick();
        chk("R7", "enable at 8 GT/s", cxl_en, 1'b1);

        // R8: short dip tolerated, long dip ends CXL
        req = "R8";
        link_rate = 3'd1; ticks(4);
        chk("R8", "short dip keeps enable", cxl_en, 1'b1);
        link_rate = 3'd3; ticks(2);
        link_rate = 3'd0; ticks(4);
        chk("R8", "no detect before limit", detect_req, 1'b0);
        tick();
        chk("R8", "detect at limit", detect_req, 1'b1);
        chk("R8", "enable cleared", cxl_en, 1'b0);
        tick();

        // R10: back to idle
        req = "R10";
        sub_state = 3'd0; link_rate = 3'd0; ticks(2);

        // R3: partner without modified sets
        req = "R3";
        sub_state = 3'd1; tick();
        send(1'b0, 1'b0, 8'hFF);
        sub_state = 3'd3; tick();
        chk("R3", "fallback done", neg_done, 1'b1);
        chk("R3", "fallback mode pcie", mode_cxl, 1'b0);
        ticks(2);
        sub_state = 3'd0; ticks(2);

        // R6: differing echo in phase 2
        req = "R6";
        local_caps = 8'h0F;
        ticks(2);
        sub_state = 3'd1; tick();
        send(1'b0, 1'b1, 8'h0B);
        sub_state = 3'd3; tick();
        send(1'b1, 1'b1, 8'h0B);
        send(1'b1, 1'b1, 8'h03);
        chk("R6", "detect on mismatch", detect_req, 1'b1);
        for (int i = 0; i < 8; i++) send(1'b1, 1'b1, 8'h0B);
        chk("R6", "no done after mismatch", neg_done, 1'b0);
        sub_state = 3'd0; ticks(2);

        // R10: leaving L0 after success clears without detect
        req = "R10";
        recov_limit = 16'd1;
        negotiate_cxl(8'h05);
        sub_state = 3'd4; link_rate = 3'd3; ticks(2);
        chk("R10", "enabled before leave", cxl_en, 1'b1);
        sub_state = 3'd0; tick();
        chk("R10", "enable cleared on leave", cxl_en, 1'b0);
        chk("R10", "no detect on leave", detect_req, 1'b0);
        chk("R10", "mode cleared on leave", mode_cxl, 1'b0);

        // R8: limit of one cycle
        req = "R8";
        negotiate_cxl(8'h0C);
        sub_state = 3'd4; link_rate = 3'd2; ticks(2);
        link_rate = 3'd0; tick();
        chk("R8", "limit one fires at once", detect_req, 1'b1);
        ticks(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule